// File: doc/BRIEF.md
# Tagged Return-Target Predictor

This block predicts where a translated-code return will land. Translation software makes two explicit moves. Before it emulates a call, it pushes a pair: the native address where translated execution resumes, and the guest instruction-pointer value that the emulated return is expected to reach. Before it emulates a return, it loads the real guest return address, read from the emulated stack, into a tag register. It then raises a return request. The block pops the newest pair and compares the stored guest tag with the tag register. A prediction is given only when the two agree.

A mismatch, or a return on an empty stack, raises a miss flag and shows no target. The caller then falls back to a slower lookup of the target. The stack holds 16 pairs as a circular buffer. A push into a full stack overwrites the oldest pair. A synchronous flush empties the stack when translations are invalidated.

Top module: `tagged_ret_stack`

## Requirements
- R1: After reset no result is shown (`pred_hit`=0, `pred_miss`=0, `pred_target`=0) and the stack is empty, so the first return reports a miss.
- R2: A return whose compare tag equals the tag stored with the newest entry gives `pred_hit`=1, `pred_miss`=0 and `pred_target` equal to that entry's native address, in the cycle after the return request.
- R3: A return whose compare tag differs from the newest stored tag gives `pred_miss`=1, `pred_hit`=0 and `pred_target`=0. The entry is still removed.
- R4: A return on an empty stack gives `pred_miss`=1 and `pred_target`=0.
- R5: Entries come back in last-in, first-out order.
- R6: The stack holds DEPTH=16 entries. A push into a full stack overwrites the oldest entry and occupancy stays at 16. After 17 pushes, 16 returns hit, newest first, and the next return misses.
- R7: When `tag_wr` and `ret_req` are high in the same cycle, the comparison uses `tag_wdata`.
- R8: The tag register keeps its value until the next `tag_wr`, so later returns without a write compare against it.
- R9: `flush` empties the stack. A push in the flush cycle is dropped, and a return in the flush cycle reports a miss.
- R10: When a push and a return occur in the same cycle, the return is judged against the current newest entry. The pushed pair then takes that entry's place, and occupancy does not change.
- R11: `pred_hit` and `pred_miss` are high only in the cycle right after a return request. They are never both high.
- R12: Tag-register writes and idle cycles never push onto or pop from the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous clear of all entries |
| push_vld | input | 1 | Call-emulation push |
| push_native | input | NATIVE_W | Native return address to store |
| push_guest | input | GUEST_W | Guest return-address tag to store |
| tag_wr | input | 1 | Write the compare-tag register |
| tag_wdata | input | GUEST_W | New compare-tag value |
| ret_req | input | 1 | Return request: pop and compare |
| pred_hit | output | 1 | Registered: prediction valid |
| pred_miss | output | 1 | Registered: tag mismatch or empty stack |
| pred_target | output | NATIVE_W | Predicted native target, zero unless `pred_hit` |

## Verification
The hardest case to reach is the wrap of the circular buffer. Seventeen pushes must arrive back to back with no pop, so the write pointer passes the oldest slot. The stack must then be drained completely to show that exactly the overwritten entry is gone and that the occupancy stopped at 16. The bench does this with a single long push burst followed by a full drain, and every pair carries a distinct native and guest value so that any off-by-one shows up as a wrong target or an early miss. The same-cycle push and return case is also driven directly, because it is the only path where a slot is rewritten in place.

// File: rtl/trs_pkg.sv
package trs_pkg;

    typedef enum logic [1:0] {
        RES_NONE = 2'd0,
        RES_HIT  = 2'd1,
        RES_MISS = 2'd2
    } ret_res_e;

    function automatic int unsigned ring_inc(input int unsigned p, input int unsigned depth);
        return (p + 1 == depth) ? 0 : p + 1;
    endfunction

    function automatic int unsigned ring_dec(input int unsigned p, input int unsigned depth);
        return (p == 0) ? depth - 1 : p - 1;
    endfunction

endpackage

// File: rtl/trs_tag_reg.sv
module trs_tag_reg #(
    parameter int GUEST_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tag_wr,
    input  logic [GUEST_W-1:0] tag_wdata,
    output logic [GUEST_W-1:0] cmp_tag
);
    logic [GUEST_W-1:0] tag_q;

    always_ff @(posedge clk) begin
        if (rst)         tag_q <= '0;
        else if (tag_wr) tag_q <= tag_wdata;
    end

    // a write in the same cycle as a return is seen by that return
    assign cmp_tag = tag_wr ? tag_wdata : tag_q;
endmodule

// File: rtl/trs_stack.sv
module trs_stack #(
    parameter int DEPTH    = 16,
    parameter int NATIVE_W = 32,
    parameter int GUEST_W  = 32,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                flush,
    input  logic                push,
    input  logic [NATIVE_W-1:0] push_native,
    input  logic [GUEST_W-1:0]  push_guest,
    input  logic                pop_req,
    output logic                pop_taken,
    output logic [NATIVE_W-1:0] top_native,
    output logic [GUEST_W-1:0]  top_guest,
    output logic [CW-1:0]       occ
);
    import trs_pkg::*;

    typedef struct packed {
        logic [NATIVE_W-1:0] native;
        logic [GUEST_W-1:0]  guest;
    } entry_t;

    entry_t        mem [DEPTH];
    logic [PW-1:0] wp;
    logic [PW-1:0] top_idx;
    logic [PW-1:0] wp_next;
    logic          wr_en;
    logic [PW-1:0] wr_idx;
    entry_t        wr_ent;

    assign top_idx   = PW'(ring_dec(int'(wp), DEPTH));
    assign wp_next   = PW'(ring_inc(int'(wp), DEPTH));
    assign pop_taken = pop_req && !flush && (occ != '0);

    assign top_native = mem[top_idx].native;
    assign top_guest  = mem[top_idx].guest;

    always_comb begin
        wr_en  = push && !flush && !rst;
        wr_idx = pop_taken ? top_idx : wp;
        wr_ent = '{native: push_native, guest: push_guest};
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_ent;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            occ <= '0;
        end else if (pop_taken && push) begin
            wp  <= wp;
            occ <= occ;
        end else if (pop_taken) begin
            wp  <= top_idx;
            occ <= occ - 1'b1;
        end else if (push) begin
            wp <= wp_next;
            if (occ != CW'(DEPTH)) occ <= occ + 1'b1;
        end
    end
endmodule

// File: rtl/tagged_ret_stack.sv
module tagged_ret_stack #(
    parameter int DEPTH    = 16,
    parameter int NATIVE_W = 32,
    parameter int GUEST_W  = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                flush,
    input  logic                push_vld,
    input  logic [NATIVE_W-1:0] push_native,
    input  logic [GUEST_W-1:0]  push_guest,
    input  logic                tag_wr,
    input  logic [GUEST_W-1:0]  tag_wdata,
    input  logic                ret_req,
    output logic                pred_hit,
    output logic                pred_miss,
    output logic [NATIVE_W-1:0] pred_target
);
    import trs_pkg::*;

    localparam int CW = $clog2(DEPTH + 1);

    logic [GUEST_W-1:0]  cmp_tag;
    logic                pop_taken;
    logic [NATIVE_W-1:0] top_native;
    logic [GUEST_W-1:0]  top_guest;
    logic [CW-1:0]       occ;
    ret_res_e            res_d, res_q;
    logic [NATIVE_W-1:0] tgt_d, tgt_q;

    trs_tag_reg #(.GUEST_W(GUEST_W)) u_tag (
        .clk(clk), .rst(rst), .tag_wr(tag_wr), .tag_wdata(tag_wdata), .cmp_tag(cmp_tag)
    );

    trs_stack #(.DEPTH(DEPTH), .NATIVE_W(NATIVE_W), .GUEST_W(GUEST_W)) u_stk (
        .clk(clk), .rst(rst), .flush(flush),
        .push(push_vld), .push_native(push_native), .push_guest(push_guest),
        .pop_req(ret_req), .pop_taken(pop_taken),
        .top_native(top_native), .top_guest(top_guest), .occ(occ)
    );

    always_comb begin
        res_d = RES_NONE;
        tgt_d = '0;
        if (ret_req) begin
            if (pop_taken && (top_guest == cmp_tag)) begin
                res_d = RES_HIT;
                tgt_d = top_native;
            end else begin
                res_d = RES_MISS;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= RES_NONE;
            tgt_q <= '0;
        end else begin
            res_q <= res_d;
            tgt_q <= tgt_d;
        end
    end

    assign pred_hit    = (res_q == RES_HIT);
    assign pred_miss   = (res_q == RES_MISS);
    assign pred_target = tgt_q;
endmodule

// File: rtl/trs_checker.sv
module trs_checker #(
    parameter int DEPTH    = 16,
    parameter int NATIVE_W = 32,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic                clk,
    input logic                rst,
    input logic                flush,
    input logic                push_vld,
    input logic                ret_req,
    input logic                pred_hit,
    input logic                pred_miss,
    input logic [NATIVE_W-1:0] pred_target,
    input logic [CW-1:0]       occ
);
    AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (rst) !(pred_hit && pred_miss)); // R11
    AST_RESULT_AFTER_RET: assert property (@(posedge clk) disable iff (rst) ret_req |=> (pred_hit || pred_miss)); // R11
    AST_QUIET_NO_RET: assert property (@(posedge clk) disable iff (rst) !ret_req |=> !(pred_hit || pred_miss)); // R11
    AST_NO_TARGET_ON_MISS: assert property (@(posedge clk) disable iff (rst) !pred_hit |-> pred_target == '0); // R3
    AST_EMPTY_MISS: assert property (@(posedge clk) disable iff (rst) (ret_req && occ == '0) |=> pred_miss); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) occ <= CW'(DEPTH)); // R6
    AST_FULL_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (occ == CW'(DEPTH) && push_vld && !ret_req && !flush) |=> occ == CW'(DEPTH)); // R6
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst) flush |=> occ == '0); // R9
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst) (!push_vld && !ret_req && !flush) |=> $stable(occ)); // R12
    AST_SWAP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (push_vld && ret_req && !flush && occ != '0) |=> $stable(occ)); // R10
endmodule

bind tagged_ret_stack trs_checker #(.DEPTH(DEPTH), .NATIVE_W(NATIVE_W)) u_chk (
    .clk(clk), .rst(rst), .flush(flush), .push_vld(push_vld), .ret_req(ret_req),
    .pred_hit(pred_hit), .pred_miss(pred_miss), .pred_target(pred_target), .occ(occ)
);

// File: tb/tb_tagged_ret_stack.sv
module tb_tagged_ret_stack;
    localparam int NW = 32;
    localparam int GW = 32;

    logic          clk = 1'b0;
    logic          rst, flush, push_vld, tag_wr, ret_req;
    logic [NW-1:0] push_native;
    logic [GW-1:0] push_guest, tag_wdata;
    logic          pred_hit, pred_miss;
    logic [NW-1:0] pred_target;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    tagged_ret_stack #(.DEPTH(16), .NATIVE_W(NW), .GUEST_W(GW)) dut (
        .clk(clk), .rst(rst), .flush(flush), .push_vld(push_vld),
        .push_native(push_native), .push_guest(push_guest),
        .tag_wr(tag_wr), .tag_wdata(tag_wdata), .ret_req(ret_req),
        .pred_hit(pred_hit), .pred_miss(pred_miss), .pred_target(pred_target)
    );

    function automatic logic [NW-1:0] nat(input int i);
        return 32'h8000_0000 | NW'(i * 16 + 3);
    endfunction
    function automatic logic [GW-1:0] gst(input int i);
        return 32'h0040_0000 + GW'(i * 4);
    endfunction

    task automatic chk(input string req, input logic [NW+1:0] act, input logic [NW+1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        flush = 0; push_vld = 0; tag_wr = 0; ret_req = 0;
        push_native = '0; push_guest = '0; tag_wdata = '0;
    endtask

    task automatic do_push(input int i);
        @(negedge clk);
        idle_inputs();
        push_vld = 1; push_native = nat(i); push_guest = gst(i);
        @(negedge clk);
        idle_inputs();
    endtask

    // return; optional tag write in same cycle; optional push in same cycle
    task automatic do_ret(input string req, input logic wr, input logic [GW-1:0] tag,
                          input logic exp_hit, input logic [NW-1:0] exp_tgt,
                          input logic also_push = 0, input int push_i = 0);
        @(negedge clk);
        idle_inputs();
        ret_req = 1; tag_wr = wr; tag_wdata = tag;
        if (also_push) begin
            push_vld = 1; push_native = nat(push_i); push_guest = gst(push_i);
        end
        @(negedge clk);
        idle_inputs();
        chk(req, {pred_hit, pred_miss, pred_target},
            {exp_hit, !exp_hit, exp_hit ? exp_tgt : {NW{1'b0}}});
    endtask

    task automatic drain();
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            idle_inputs(); ret_req = 1;
        end
        @(negedge clk);
        idle_inputs();
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 outputs idle after reset", {pred_hit, pred_miss, pred_target}, '0);
        do_ret("R1 first return misses", 1, gst(0), 0, '0);
    endtask

    task automatic t_match_lifo();
        do_push(1); do_push(2); do_push(3);
        do_ret("R2 hit newest", 1, gst(3), 1, nat(3));
        do_ret("R5 lifo second", 1, gst(2), 1, nat(2));
        do_ret("R5 lifo third", 1, gst(1), 1, nat(1));
        do_ret("R4 empty after drain", 1, gst(1), 0, '0);
    endtask

    task automatic t_mismatch();
        do_push(4); do_push(5);
        do_ret("R3 wrong tag misses", 1, gst(4), 0, '0);
        do_ret("R3 mismatched entry consumed", 1, gst(4), 1, nat(4));
        @(negedge clk);
        chk("R11 no result without return", {pred_hit, pred_miss}, 2'b00);
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 17; i++) do_push(100 + i);
        for (int i = 16; i >= 1; i--)
            do_ret("R6 drain after wrap", 1, gst(100 + i), 1, nat(100 + i));
        do_ret("R6 oldest overwritten", 1, gst(100), 0, '0);
    endtask

    task automatic t_tag_hold();
        // two entries with the same guest tag
        @(negedge clk); idle_inputs();
        push_vld = 1; push_native = nat(20); push_guest = gst(9);
        @(negedge clk);
        push_native = nat(21);
        @(negedge clk); idle_inputs();
        tag_wr = 1; tag_wdata = gst(77);
        @(negedge clk); idle_inputs();
        tag_wr = 1; tag_wdata = gst(9);
        @(negedge clk); idle_inputs();
        chk("R12 tag write makes no result", {pred_hit, pred_miss}, 2'b00);
        do_ret("R8 held tag hit newest", 0, '0, 1, nat(21));
        do_ret("R12 tag writes did not pop", 0, '0, 1, nat(20));
        do_ret("R8 empty after held-tag pops", 0, '0, 0, '0);
    endtask

    task automatic t_same_cycle_tag();
        do_push(30);
        @(negedge clk); idle_inputs(); tag_wr = 1; tag_wdata = gst(99);
        @(negedge clk); idle_inputs();
        do_ret("R7 new tag used same cycle", 1, gst(30), 1, nat(30));
    endtask

    task automatic t_flush();
        do_push(40); do_push(41);
        @(negedge clk); idle_inputs();
        flush = 1; push_vld = 1; push_native = nat(42); push_guest = gst(42);
        @(negedge clk); idle_inputs();
        do_ret("R9 flush cleared stack", 1, gst(42), 0, '0);
        do_push(43);
        @(negedge clk); idle_inputs();
        flush = 1; ret_req = 1; tag_wr = 1; tag_wdata = gst(43);
        @(negedge clk); idle_inputs();
        chk("R9 return during flush misses", {pred_hit, pred_miss, pred_target}, {2'b01, {NW{1'b0}}});
        do_ret("R9 empty after flush", 1, gst(43), 0, '0);
    endtask

    task automatic t_swap();
        do_push(50); do_push(51);
        do_ret("R10 return sees old top", 1, gst(51), 1, nat(51), 1, 52);
        do_ret("R10 pushed pair replaced top", 1, gst(52), 1, nat(52));
        do_ret("R10 lower entry intact", 1, gst(50), 1, nat(50));
        do_ret("R10 occupancy unchanged", 1, gst(50), 0, '0);
        do_ret("R10 push on empty during return", 1, gst(60), 0, '0, 1, 60);
        do_ret("R10 push kept when stack empty", 1, gst(60), 1, nat(60));
    endtask

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_match_lifo();
        t_mismatch();
        t_wrap();
        t_tag_hold();
        t_same_cycle_tag();
        t_flush();
        drain();
        t_swap();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL watchdog run hung");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule